// File: doc/BRIEF.md
# Six-Function Word ALU

This block is the arithmetic and logic core of a 16-bit word datapath. It takes two operand words and a three-bit function code and returns one result word in the same cycle. It has no clock, no storage and no status flags. The surrounding datapath registers its operands and result wherever its timing plan needs them.

Each of the six operations (add, subtract, bitwise AND, bitwise XOR, logical left shift and logical right shift) is always computed, whatever the function code says. A final selector then passes one candidate to the output. Add and subtract share a single ripple-carry chain of one-bit full adders. For subtraction the second operand is inverted and the chain's carry-in is forced to one. Any carry out of the top bit is dropped, so results wrap modulo 2^16.

Top module: `alu16_core`

## Requirements
- R1: Function code 3'b000 drives `result` with `opa + opb` truncated to 16 bits; the carry out is discarded (0xFFFF + 0x0003 gives 0x0002).
- R2: Function code 3'b001 drives `result` with `opa - opb` modulo 2^16 (0x0000 - 0x0001 gives 0xFFFF).
- R3: Function code 3'b010 drives `result` with the bitwise AND of the two operands.
- R4: Function code 3'b011 drives `result` with the bitwise XOR of the two operands.
- R5: Function code 3'b100 shifts `opa` left by `opb[3:0]` positions and fills with zeros. `opb[15:4]` has no effect on the result.
- R6: Function code 3'b101 shifts `opa` right by `opb[3:0]` positions and fills with zeros, never with copies of the sign bit (0x8000 shifted by 15 gives 0x0001).
- R7: Function codes 3'b110 and 3'b111 drive `result` to 0x0000 for any operands.
- R8: A shift amount of zero, under either shift code, passes `opa` to `result` unchanged, even when the upper bits of `opb` are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand; the minuend, and the word that is shifted |
| opb | input | 16 | Second operand; its low four bits are the shift amount |
| func | input | 3 | Function code selecting the result |
| result | output | 16 | Selected result word |

## Verification
The cases hardest to reach with random operands are the edges of the word: a carry that ripples through all sixteen bits and falls off the top, a borrow from zero, and shifts by exactly 0 or 15 while junk sits in the upper bits of the second operand. The stimulus first sweeps a corner set of operands (zero, all ones, 0x8000, 0x7FFF, 0x0001, 0x00F0, 0xFFF0) against every function code, including the two unused codes. Random operands follow, and each result is compared on every clock with a behavioural integer model.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int FN_W = 3;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 3'b000,
        FN_SUB = 3'b001,
        FN_AND = 3'b010,
        FN_XOR = 3'b011,
        FN_SHL = 3'b100,
        FN_SHR = 3'b101
    } alu_fn_e;

endpackage

// File: rtl/alu16_ripple_adder.sv
module alu16_ripple_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum
);
    logic [W-1:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // sum is the odd parity of the three inputs
        assign sum[i] = x[i] ^ y[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            // carry is the majority of the three inputs
            assign carry[i+1] = (x[i] & y[i]) | (x[i] & carry[i]) | (y[i] & carry[i]);
        end
    end
endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
    parameter int W          = 16,
    parameter int SHW        = 4,
    parameter bit TOWARD_MSB = 1'b1
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stage [0:SHW];

    assign stage[0] = din;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        if (TOWARD_MSB) begin : g_left
            assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
        end else begin : g_right
            assign stage[s+1] = amt[s] ? (stage[s] >> (1 << s)) : stage[s];
        end
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic [FN_W-1:0] func,
    output logic [W-1:0]    result
);
    localparam int SHW = $clog2(W);

    typedef struct packed {
        logic [W-1:0] arith;
        logic [W-1:0] conj;
        logic [W-1:0] excl;
        logic [W-1:0] lsh;
        logic [W-1:0] rsh;
    } cand_t;

    cand_t        cand_d;
    logic         sub_sel;
    logic [W-1:0] y_eff;
    logic [W-1:0] arith_w;
    logic [W-1:0] lsh_w;
    logic [W-1:0] rsh_w;

    assign sub_sel = (func == FN_SUB);
    assign y_eff   = opb ^ {W{sub_sel}};

    alu16_ripple_adder #(.W(W)) u_adder (
        .x   (opa),
        .y   (y_eff),
        .cin (sub_sel),
        .sum (arith_w)
    );

    alu16_shifter #(.W(W), .SHW(SHW), .TOWARD_MSB(1'b1)) u_shl (
        .din  (opa),
        .amt  (opb[SHW-1:0]),
        .dout (lsh_w)
    );

    alu16_shifter #(.W(W), .SHW(SHW), .TOWARD_MSB(1'b0)) u_shr (
        .din  (opa),
        .amt  (opb[SHW-1:0]),
        .dout (rsh_w)
    );

    // every candidate is formed in parallel
    always_comb begin
        cand_d.arith = arith_w;
        cand_d.conj  = opa & opb;
        cand_d.excl  = opa ^ opb;
        cand_d.lsh   = lsh_w;
        cand_d.rsh   = rsh_w;
    end

    always_comb begin
        case (func)
            FN_ADD, FN_SUB: result = cand_d.arith;
            FN_AND:         result = cand_d.conj;
            FN_XOR:         result = cand_d.excl;
            FN_SHL:         result = cand_d.lsh;
            FN_SHR:         result = cand_d.rsh;
            default:        result = '0;
        endcase
    end
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input logic [W-1:0]    opa,
    input logic [W-1:0]    opb,
    input logic [FN_W-1:0] func,
    input logic [W-1:0]    result
);
    localparam int SHW = $clog2(W);

    logic [W-1:0] undo_add;
    logic [W-1:0] undo_sub;
    logic [W-1:0] low_mask;
    logic [W-1:0] high_mask;

    always_comb begin
        undo_add  = result - opb;
        undo_sub  = result + opb;
        low_mask  = ~({W{1'b1}} << opb[SHW-1:0]);
        high_mask = ~({W{1'b1}} >> opb[SHW-1:0]);
    end

    always_comb begin
        if (func == FN_ADD) assert_add_inverse_R1: assert (undo_add == opa)
            else $error("add result does not invert");
        if (func == FN_SUB) assert_sub_inverse_R2: assert (undo_sub == opa)
            else $error("sub result does not invert");
        if (func == FN_AND) assert_and_subset_R3: assert ((result & ~opa) == '0 && (result & ~opb) == '0)
            else $error("and result has bits outside operands");
        if (func == FN_XOR) assert_xor_inverse_R4: assert ((result ^ opb) == opa)
            else $error("xor result does not invert");
        if (func == FN_SHL) assert_shl_zero_fill_R5: assert ((result & low_mask) == '0)
            else $error("left shift did not fill low bits with zero");
        if (func == FN_SHR) assert_shr_zero_fill_R6: assert ((result & high_mask) == '0)
            else $error("right shift did not fill high bits with zero");
        if (func[2:1] == 2'b11) assert_unused_zero_R7: assert (result == '0)
            else $error("unused code gave nonzero result");
        if ((func == FN_SHL || func == FN_SHR) && opb[SHW-1:0] == '0)
            assert_shift_zero_pass_R8: assert (result == opa)
                else $error("zero shift altered operand");
    end
endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_alu16_core_chk (
    .opa    (opa),
    .opb    (opb),
    .func   (func),
    .result (result)
);

// File: tb/test_alu16_core.sv
module test_alu16_core;
    logic        clk = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [2:0]  func = '0;
    logic [15:0] result;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    alu16_core i_alu16_core (
        .opa    (opa),
        .opb    (opb),
        .func   (func),
        .result (result)
    );

    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b, input logic [2:0] f);
        int unsigned ia = a;
        int unsigned ib = b;
        int unsigned n  = b % 16;
        int unsigned r;
        case (f)
            3'd0:    r = (ia + ib) % 65536;
            3'd1:    r = (ia + 65536 - ib) % 65536;
            3'd2:    r = ia & ib;
            3'd3:    r = ia ^ ib;
            3'd4:    r = (ia * (32'd1 << n)) % 65536;
            3'd5:    r = ia / (32'd1 << n);
            default: r = 0;
        endcase
        return r[15:0];
    endfunction

    function automatic string tag_of(input logic [15:0] b, input logic [2:0] f);
        if ((f == 3'd4 || f == 3'd5) && b[3:0] == 4'd0) return "R8";
        case (f)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [2:0] f);
        logic [15:0] exp;
        @(negedge clk);
        opa = a; opb = b; func = f;
        #5;
        exp = model(a, b, f);
        total++;
        if (result !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h f=%0d actual=%h expected=%h",
                     tag_of(b, f), a, b, f, result, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] corners [7];
        corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
        corners[3] = 16'h7FFF; corners[4] = 16'h0001; corners[5] = 16'h00F0;
        corners[6] = 16'hFFF0;
        // idle state: all inputs zero gives zero (R1 path)
        apply(16'h0000, 16'h0000, 3'd0);
        // directed edges
        apply(16'hFFFF, 16'h0003, 3'd0);   // R1 carry dropped -> 0002
        apply(16'h0000, 16'h0001, 3'd1);   // R2 borrow -> FFFF
        apply(16'h8000, 16'h000F, 3'd5);   // R6 no sign fill -> 0001
        apply(16'h0001, 16'hFFFF, 3'd4);   // R5 upper bits ignored -> 8000
        apply(16'hA5A5, 16'hFFF0, 3'd4);   // R8 zero shift with junk
        apply(16'hA5A5, 16'hFFF0, 3'd5);   // R8
        apply(16'h1234, 16'h5678, 3'd6);   // R7
        apply(16'hFFFF, 16'hFFFF, 3'd7);   // R7
        apply(16'hF0F0, 16'h3C3C, 3'd2);   // R3
        apply(16'hF0F0, 16'h3C3C, 3'd3);   // R4
        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    apply(corners[i], corners[j], f[2:0]);
        for (int k = 0; k < 4000; k++)
            apply($urandom(), $urandom(), $urandom() % 8);
        for (int s = 0; s < 16; s++) begin
            apply(16'hC3A1, 16'(s) | 16'hAB00, 3'd4);
            apply(16'hC3A1, 16'(s) | 16'hAB00, 3'd5);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule